// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block converts a logical address into a linear address. The logical address is a 64-bit segment descriptor, held by the caller in a cache register, together with a 32-bit offset. The block rebuilds the segment base and limit from the descriptor, where each is split across two fields. It scales the limit when page-sized granularity is selected, and it reverses the valid offset range for expand-down data segments. It also checks that the segment is present.

A caller pulses `req` for one cycle with a descriptor, an offset and an access kind. One cycle later the block pulses `rsp_valid`. With that pulse it gives either the linear address or a fault flag and a fault cause. If the access succeeds on a descriptor whose accessed bit is still clear, it also raises an update request. That request carries the descriptor with the accessed bit set, so the caller can write it back to the descriptor table.

Top module: `seg_xlate`

## Requirements
- R1: The base is built from descriptor bits 39:16 as bits 23:0 and bits 63:56 as bits 31:24. A successful access returns base + offset modulo 2^32.
- R2: The raw 20-bit limit is built from descriptor bits 15:0 as bits 15:0 and bits 51:48 as bits 19:16. When bit 55 is clear, an expand-up access is in range when offset <= limit, so the segment holds limit + 1 bytes.
- R3: When bit 55 is set, the effective limit is raw limit × 4096 + 4095. The last byte of the final 4 KB unit is still in range.
- R4: A segment is expand-down when bit 44 = 1, bit 43 = 0 and bit 42 = 1. Its valid offsets satisfy effective limit < offset <= upper bound. The upper bound is 0000FFFFh when bit 54 is clear and FFFFFFFFh when bit 54 is set.
- R5: When bit 47 (present) is clear, the access faults with cause 2'b01. This cause takes priority over a limit violation.
- R6: Results are registered. `rsp_valid` is high for exactly the cycle after each cycle with `req` high, and is low otherwise.
- R7: The fault cause is 2'b00 for none, 2'b01 for not present and 2'b10 for a limit violation. `fault` is high exactly when the cause is nonzero. On a fault, `lin_addr` is 0.
- R8: `upd_req` pulses with `rsp_valid` only on a successful access whose descriptor has bit 40 (accessed) clear. `upd_desc` then equals the input descriptor with bit 40 set. No update is requested on a fault or when bit 40 is already set.
- R9: The access kind (2'b00 read, 2'b01 write, 2'b10 fetch; 2'b11 must not be driven) does not change the address, the fault or the update request.
- R10: After reset, `rsp_valid`, `fault` and `upd_req` are low, and `fault_cause` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Translation request strobe |
| desc | input | 64 | Cached segment descriptor |
| offset | input | 32 | Offset within the segment |
| kind | input | 2 | Access kind: read, write or fetch |
| rsp_valid | output | 1 | Result valid pulse |
| lin_addr | output | 32 | Linear address (0 on a fault) |
| fault | output | 1 | Access faulted |
| fault_cause | output | 2 | Fault cause code |
| upd_req | output | 1 | Request to write back the descriptor with accessed set |
| upd_desc | output | 64 | Descriptor with the accessed bit set |

## Verification
The assertions check on every cycle:
- that the result pulse follows each request one cycle later;
- that an absent segment always reports cause 01;
- that the fault flag agrees with the cause and a faulted address reads zero;
- that an update request appears only on a clean access and never for a descriptor already marked accessed;
- that an in-range offset sits on the correct side of the effective limit.

Only the bench's scenarios show the rest:
- the exact placement of the split base and limit fields;
- the 4 KB scaling with its filled low bits;
- both upper bounds of expand-down segments;
- wraparound of the address sum;
- the exact boundary offsets on each side of a limit.

// File: rtl/segx_pkg.sv
package segx_pkg;

  localparam int DESC_W  = 64;
  localparam int LIN_W   = 32;
  localparam int LIM_W   = 20;
  localparam int GRAN_SH = LIN_W - LIM_W;
  localparam int SMALL_W = 16;

  localparam int B_ACC   = 40;
  localparam int B_EXPDN = 42;
  localparam int B_EXEC  = 43;
  localparam int B_SYS   = 44;
  localparam int B_PRES  = 47;
  localparam int B_BIG   = 54;
  localparam int B_GRAN  = 55;

  typedef enum logic [1:0] {
    FC_NONE   = 2'b00,
    FC_ABSENT = 2'b01,
    FC_LIMIT  = 2'b10
  } fcause_e;

  typedef enum logic [1:0] {
    K_READ  = 2'b00,
    K_WRITE = 2'b01,
    K_FETCH = 2'b10
  } kind_e;

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [LIM_W-1:0] lim;
    logic             gran;
    logic             big;
    logic             present;
    logic             accessed;
    logic             expdn;
  } seg_attr_t;

  function automatic seg_attr_t unpack_desc(input logic [DESC_W-1:0] d);
    seg_attr_t a;
    a.base     = {d[63:56], d[39:16]};
    a.lim      = {d[51:48], d[15:0]};
    a.gran     = d[B_GRAN];
    a.big      = d[B_BIG];
    a.present  = d[B_PRES];
    a.accessed = d[B_ACC];
    a.expdn    = d[B_SYS] & ~d[B_EXEC] & d[B_EXPDN];
    return a;
  endfunction

  function automatic logic [LIN_W-1:0] scale_limit(input logic [LIM_W-1:0] lim,
                                                   input logic gran);
    if (gran) return {lim, {GRAN_SH{1'b1}}};
    return LIN_W'(lim);
  endfunction

  function automatic logic [LIN_W-1:0] upper_bound(input logic big);
    if (big) return {LIN_W{1'b1}};
    return LIN_W'({SMALL_W{1'b1}});
  endfunction

  function automatic logic offset_ok(input logic [LIN_W-1:0] off,
                                     input logic [LIN_W-1:0] eff,
                                     input logic [LIN_W-1:0] top,
                                     input logic expdn);
    if (expdn) return (off > eff) && (off <= top);
    return off <= eff;
  endfunction

endpackage

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import segx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] lim,
  input  logic             gran,
  input  logic             big,
  input  logic             expdn,
  input  logic [LIN_W-1:0] offset,
  output logic [LIN_W-1:0] eff_lim,
  output logic             in_range
);

  logic [LIN_W-1:0] top_bound;

  always_comb begin
    eff_lim   = scale_limit(lim, gran);
    top_bound = upper_bound(big);
    in_range  = offset_ok(offset, eff_lim, top_bound, expdn);
  end

  // R2: an expand-up offset judged in range never lies past the limit
  p_up_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!expdn && in_range) |-> (offset <= eff_lim));

  // R4: an expand-down offset judged in range lies above the limit and within the bound
  p_expdn_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expdn && in_range) |-> ((offset > eff_lim) && (big || offset[LIN_W-1:SMALL_W] == '0)));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import segx_pkg::*;
(
  input  logic [LIN_W-1:0] base,
  input  logic [LIN_W-1:0] offset,
  input  logic             ok,
  output logic [LIN_W-1:0] lin
);

  logic [LIN_W-1:0] sum;

  always_comb begin
    sum = base + offset;
    lin = ok ? sum : '0;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import segx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [DESC_W-1:0] desc,
  input  logic [LIN_W-1:0]  offset,
  input  logic [1:0]        kind,
  output logic              rsp_valid,
  output logic [LIN_W-1:0]  lin_addr,
  output logic              fault,
  output logic [1:0]        fault_cause,
  output logic              upd_req,
  output logic [DESC_W-1:0] upd_desc
);

  seg_attr_t        attr;
  logic [LIN_W-1:0] eff_lim;
  logic             lim_ok;
  logic [LIN_W-1:0] lin_nxt;
  fcause_e          cause_nxt;
  logic             access_ok;
  logic             need_upd;

  assign attr = unpack_desc(desc);

  seg_limit_check u_lim (
    .clk      (clk),
    .rst_n    (rst_n),
    .lim      (attr.lim),
    .gran     (attr.gran),
    .big      (attr.big),
    .expdn    (attr.expdn),
    .offset   (offset),
    .eff_lim  (eff_lim),
    .in_range (lim_ok)
  );

  always_comb begin
    if (!attr.present)  cause_nxt = FC_ABSENT;
    else if (!lim_ok)   cause_nxt = FC_LIMIT;
    else                cause_nxt = FC_NONE;
    access_ok = (cause_nxt == FC_NONE);
    need_upd  = access_ok && !attr.accessed;
  end

  seg_addr_gen u_add (
    .base   (attr.base),
    .offset (offset),
    .ok     (access_ok),
    .lin    (lin_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      lin_addr    <= '0;
      fault       <= 1'b0;
      fault_cause <= FC_NONE;
      upd_req     <= 1'b0;
      upd_desc    <= '0;
    end else begin
      rsp_valid <= req;
      upd_req   <= req && need_upd;
      if (req) begin
        lin_addr    <= lin_nxt;
        fault       <= !access_ok;
        fault_cause <= cause_nxt;
        upd_desc    <= desc | (DESC_W'(1) << B_ACC);
      end
    end
  end

  // R6: every request yields a result pulse in the next cycle
  p_valid_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);

  // R6: no result pulse without a request in the previous cycle
  p_valid_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);

  // R5: an absent segment always reports the not-present cause
  p_absent_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !desc[B_PRES]) |=> (fault && fault_cause == FC_ABSENT));

  // R7: the fault flag agrees with the cause, and a faulted address reads zero
  p_cause_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (fault == (fault_cause != FC_NONE)));
  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault) |-> (lin_addr == '0));

  // R8: an update comes only with a clean result and carries the accessed bit
  p_upd_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> (rsp_valid && !fault && upd_desc[B_ACC]));
  p_upd_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && desc[B_ACC]) |=> !upd_req);

  // R9: the reserved access kind is never presented
  p_kind_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (kind != 2'b11));

endmodule

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [63:0] desc = '0;
  logic [31:0] offset = '0;
  logic [1:0]  kind = 2'b00;
  logic        rsp_valid;
  logic [31:0] lin_addr;
  logic        fault;
  logic [1:0]  fault_cause;
  logic        upd_req;
  logic [63:0] upd_desc;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n), .req(req), .desc(desc), .offset(offset), .kind(kind),
    .rsp_valid(rsp_valid), .lin_addr(lin_addr), .fault(fault),
    .fault_cause(fault_cause), .upd_req(upd_req), .upd_desc(upd_desc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // data descriptor: S=1, writable, expand-down optional
  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                     input bit g, input bit d, input bit p,
                                     input bit a, input bit ed);
    logic [63:0] r = '0;
    r[15:0]  = lim[15:0];
    r[51:48] = lim[19:16];
    r[39:16] = base[23:0];
    r[63:56] = base[31:24];
    r[55] = g; r[54] = d; r[47] = p; r[44] = 1'b1; r[43] = 1'b0;
    r[42] = ed; r[41] = 1'b1; r[40] = a;
    return r;
  endfunction

  // independent model from the requirements
  task automatic run(input string tag, input logic [63:0] dsc, input logic [31:0] off,
                     input logic [1:0] k);
    longint unsigned base, lim, eff, top, sum;
    bit ed, ok_lim, pres;
    logic [1:0] ecause;
    base = ((dsc >> 16) & 64'hFF_FFFF) | (((dsc >> 56) & 64'hFF) << 24);
    lim  = (dsc & 64'hFFFF) | (((dsc >> 48) & 64'hF) << 16);
    eff  = dsc[55] ? (lim * 4096 + 4095) : lim;
    top  = dsc[54] ? 64'hFFFF_FFFF : 64'hFFFF;
    ed   = dsc[44] && !dsc[43] && dsc[42];
    pres = dsc[47];
    ok_lim = ed ? (off > eff && off <= top) : (off <= eff);
    ecause = !pres ? 2'b01 : (!ok_lim ? 2'b10 : 2'b00);
    sum = (base + off) % 64'h1_0000_0000;
    @(negedge clk);
    desc = dsc; offset = off; kind = k; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R6 valid"}, rsp_valid, 1);
    chk({tag, " R7 cause"}, fault_cause, ecause);
    chk({tag, " R7 fault"}, fault, ecause != 2'b00);
    chk({tag, " R1 addr"}, lin_addr, (ecause == 2'b00) ? sum : 0);
    chk({tag, " R8 upd"}, upd_req, (ecause == 2'b00) && !dsc[40]);
    if (upd_req) chk({tag, " R8 desc"}, upd_desc, dsc | (64'd1 << 40));
    @(negedge clk);
    chk({tag, " R6 pulse"}, rsp_valid, 0);
    chk({tag, " R8 pulse"}, upd_req, 0);
  endtask

  task automatic t_reset();
    chk("R10 valid", rsp_valid, 0);
    chk("R10 fault", fault, 0);
    chk("R10 upd", upd_req, 0);
    chk("R10 cause", fault_cause, 0);
  endtask

  task automatic t_byte_limit();
    logic [63:0] d = mk(32'h12_345678, 20'h0_0FFF, 0, 1, 1, 1, 0);
    run("R2 inside", d, 32'h0000_0100, 2'b00);
    run("R2 edge", d, 32'h0000_0FFF, 2'b00);
    run("R2 past", d, 32'h0000_1000, 2'b00);
    run("R2 hifield", mk(32'h0, 20'hA_0000, 0, 1, 1, 1, 0), 32'h000A_0000, 2'b00);
  endtask

  task automatic t_base_fields();
    run("R1 split", mk(32'hAB_CDEF01, 20'hF_FFFF, 1, 1, 1, 1, 0), 32'h0000_0010, 2'b00);
    run("R1 wrap", mk(32'hFFFF_F000, 20'hF_FFFF, 1, 1, 1, 1, 0), 32'h0000_2000, 2'b00);
  endtask

  task automatic t_gran();
    logic [63:0] d = mk(32'h1000_0000, 20'h0_0002, 1, 1, 1, 1, 0);
    run("R3 tail", d, 32'h0000_2FFF, 2'b00);
    run("R3 past", d, 32'h0000_3000, 2'b00);
  endtask

  task automatic t_expdn();
    logic [63:0] d16 = mk(32'h0002_0000, 20'h0_00FF, 0, 0, 1, 1, 1);
    logic [63:0] d32 = mk(32'h0002_0000, 20'h0_00FF, 0, 1, 1, 1, 1);
    run("R4 at lim", d16, 32'h0000_00FF, 2'b01);
    run("R4 above", d16, 32'h0000_0100, 2'b01);
    run("R4 top16", d16, 32'h0000_FFFF, 2'b01);
    run("R4 over16", d16, 32'h0001_0000, 2'b01);
    run("R4 top32", d32, 32'hFFFF_FFFF, 2'b01);
    run("R4 gran", mk(32'h0, 20'h0_0001, 1, 1, 1, 1, 1), 32'h0000_1FFF, 2'b00);
  endtask

  task automatic t_absent();
    run("R5 absent", mk(32'h100, 20'hF_FFFF, 0, 1, 0, 1, 0), 32'h10, 2'b00);
    run("R5 prio", mk(32'h100, 20'h0_0001, 0, 1, 0, 1, 0), 32'h500, 2'b00);
  endtask

  task automatic t_accessed();
    run("R8 clear", mk(32'h4000, 20'h0_0FFF, 0, 1, 1, 0, 0), 32'h20, 2'b01);
    run("R8 fault", mk(32'h4000, 20'h0_0FFF, 0, 1, 1, 0, 0), 32'h2000, 2'b01);
    run("R8 set", mk(32'h4000, 20'h0_0FFF, 0, 1, 1, 1, 0), 32'h20, 2'b01);
  endtask

  task automatic t_kind();
    logic [63:0] d = mk(32'h8000_0000, 20'h0_0FFF, 0, 1, 1, 0, 0);
    run("R9 read", d, 32'h44, 2'b00);
    run("R9 write", d, 32'h44, 2'b01);
    run("R9 fetch", d, 32'h44, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 idle", rsp_valid, 0);
    t_byte_limit();
    t_base_fields();
    t_gran();
    t_expdn();
    t_absent();
    t_accessed();
    t_kind();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule